// File: doc/BRIEF.md
# Parallel Insertion Sorting Register Array

This block holds up to a fixed number of keys in a column of cells and keeps them in ascending order from cell 0 downward while new keys arrive, one per clock. When a key is offered, every cell works out its own next value at the same time. The inputs to that choice are the offered key, the cell's own stored key and one decision bit from the cell directly above. Because no decision depends on a chain of other decisions, an insert costs one cycle however many cells are occupied.

The column is read in parallel, as every key together with its occupancy bit. When every cell is occupied, a flag says so. A synchronous clear empties the column. If an insert arrives while the column is full, the largest key is dropped. That key is either the one pushed out of the last cell or the offered key itself.

Top module: `sort_column`

## Requirements
- R1: After reset, or in any cycle after `clr` is high, every occupancy bit is 0 and `isFull` is 0. `clr` takes priority over a simultaneous insert.
- R2: In a cycle with `inValid` high, each occupied cell whose stored key is strictly greater than `inKey` is displaced. The cell below it takes its old key on the next edge.
- R3: A displaced cell takes the old key of the cell above it when that cell is also displaced. Otherwise it takes `inKey`. Cell 0 always takes `inKey` when displaced.
- R4: An empty cell takes the pushed key when the cell above is displaced. It takes `inKey` when the cell above is occupied and not displaced, or when it is cell 0. In either case it becomes occupied.
- R5: Occupied cells always form a contiguous block that starts at cell 0. Keys read from cell 0 downward are non-decreasing.
- R6: An offered key equal to a stored key is placed below all stored copies of that key, so earlier arrivals stay above.
- R7: One key is accepted every cycle that `inValid` is high, and the new contents are visible after that single edge.
- R8: `isFull` equals the occupancy of the last cell. An insert into a full column drops the largest key among the stored keys and `inKey`, and the column stays full.
- R9: A cycle with `inValid` low and `clr` low leaves all keys and occupancy bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all cells |
| inValid | input | 1 | An insert is offered this cycle |
| inKey | input | KEY_W | Key to insert |
| isFull | output | 1 | All cells occupied |
| cellKeys | output | DEPTH*KEY_W | Key of cell i at bits [i*KEY_W +: KEY_W] |
| cellUsed | output | DEPTH | Occupancy bit i belongs to cell i |

## Verification
The hardest situation to create is a full column where a run of equal keys straddles the last cell. In that state the stability rule and the overflow drop both decide what survives. The bench reaches it by filling the column with a descending run followed by duplicates. It then offers one key smaller than everything stored, one equal to the last stored key, and one larger than everything stored. It compares the column with a software model kept as a sorted list after each of these inserts.

// File: rtl/sort_column_pkg.sv
package sort_column_pkg;
  typedef struct packed {
    logic doInsert;
    logic doClear;
  } sortStrobes_t;
endpackage

// File: rtl/sort_column_ctrl.sv
module sort_column_ctrl
  import sort_column_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inValid,
  output sortStrobes_t strobes
);
  always_comb begin
    strobes.doClear  = clr;
    strobes.doInsert = inValid & ~clr;
  end

  // R1
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doClear |-> !strobes.doInsert);
endmodule

// File: rtl/sort_column_dp.sv
module sort_column_dp
  import sort_column_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int KEY_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  sortStrobes_t           strobes,
  input  logic [KEY_W-1:0]       inKey,
  output logic [DEPTH*KEY_W-1:0] cellKeys,
  output logic [DEPTH-1:0]       cellUsed
);
  localparam int LAST = DEPTH - 1;

  logic [KEY_W-1:0] keyQ [DEPTH];
  logic [DEPTH-1:0] usedQ;
  logic [DEPTH-1:0] moveDown;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic upMove;
    logic upUsed;
    logic [KEY_W-1:0] upKey;
    logic [KEY_W-1:0] nextKey;
    logic nextUsed;
    logic loadEn;

    if (i == 0) begin : g_top
      assign upMove = 1'b0;
      assign upUsed = 1'b1;
      assign upKey  = '0;
    end else begin : g_mid
      assign upMove = moveDown[i-1];
      assign upUsed = usedQ[i-1];
      assign upKey  = keyQ[i-1];
    end

    // strict compare: equal keys stay put, so the sort is stable
    assign moveDown[i] = usedQ[i] && (inKey < keyQ[i]);

    always_comb begin
      nextKey  = keyQ[i];
      nextUsed = usedQ[i];
      loadEn   = 1'b0;
      if (usedQ[i]) begin
        if (moveDown[i]) begin
          loadEn  = 1'b1;
          nextKey = upMove ? upKey : inKey;
        end
      end else if (upMove) begin
        loadEn   = 1'b1;
        nextKey  = upKey;
        nextUsed = 1'b1;
      end else if (upUsed) begin
        loadEn   = 1'b1;
        nextKey  = inKey;
        nextUsed = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        usedQ[i] <= 1'b0;
        keyQ[i]  <= '0;
      end else if (strobes.doClear) begin
        usedQ[i] <= 1'b0;
      end else if (strobes.doInsert && loadEn) begin
        usedQ[i] <= nextUsed;
        keyQ[i]  <= nextKey;
      end
    end

    assign cellKeys[i*KEY_W +: KEY_W] = keyQ[i];
    assign cellUsed[i] = usedQ[i];

    if (i > 0) begin : g_chk
      // R5
      contiguous_chk: assert property (@(posedge clk) disable iff (!rstN)
        usedQ[i] |-> usedQ[i-1]);
      // R5
      ordered_chk: assert property (@(posedge clk) disable iff (!rstN)
        usedQ[i] |-> (keyQ[i-1] <= keyQ[i]));
      // R2
      push_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strobes.doInsert && moveDown[i-1]) |=> (usedQ[i] && keyQ[i] == $past(keyQ[i-1])));
    end
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.doInsert && !strobes.doClear) |=> ($stable(usedQ) && keyQ[0] == $past(keyQ[0])));
  // R1
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doClear |=> (usedQ == '0));
  // R8
  stay_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (usedQ[LAST] && !strobes.doClear) |=> usedQ[LAST]);
endmodule

// File: rtl/sort_column.sv
module sort_column
  import sort_column_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int KEY_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   clr,
  input  logic                   inValid,
  input  logic [KEY_W-1:0]       inKey,
  output logic                   isFull,
  output logic [DEPTH*KEY_W-1:0] cellKeys,
  output logic [DEPTH-1:0]       cellUsed
);
  sortStrobes_t strobes;

  sort_column_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .clr(clr), .inValid(inValid), .strobes(strobes));

  sort_column_dp #(.DEPTH(DEPTH), .KEY_W(KEY_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inKey(inKey),
    .cellKeys(cellKeys), .cellUsed(cellUsed));

  assign isFull = cellUsed[DEPTH-1];

  // R7
  grow_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !clr && !isFull) |=> ($countones(cellUsed) == $countones($past(cellUsed)) + 1));
endmodule

// File: tb/sort_column_tb_top.sv
module sort_column_tb_top;
  localparam int DEPTH = 8;
  localparam int KEY_W = 8;

  logic clk = 0;
  logic rstN = 0;
  logic clr = 0;
  logic inValid = 0;
  logic [KEY_W-1:0] inKey = '0;
  logic isFull;
  logic [DEPTH*KEY_W-1:0] cellKeys;
  logic [DEPTH-1:0] cellUsed;

  int checks = 0;
  int errors = 0;
  int modelKeys [DEPTH];
  int modelCnt = 0;

  always #2 clk = ~clk;

  sort_column #(.DEPTH(DEPTH), .KEY_W(KEY_W)) dut_i (.*);

  task automatic modelInsert(input int k);
    int pos = modelCnt;
    for (int i = 0; i < modelCnt; i++)
      if (k < modelKeys[i]) begin pos = i; break; end
    if (pos >= DEPTH) return;
    for (int i = DEPTH - 1; i > pos; i--) modelKeys[i] = modelKeys[i-1];
    modelKeys[pos] = k;
    if (modelCnt < DEPTH) modelCnt++;
  endtask

  task automatic compare(input string req);
    logic [DEPTH-1:0] expUsed;
    for (int i = 0; i < DEPTH; i++) expUsed[i] = (i < modelCnt);
    checks++;
    if (cellUsed !== expUsed || isFull !== (modelCnt == DEPTH)) begin
      errors++;
      $display("FAIL %s used actual %b full %b expected %b full %b", req, cellUsed, isFull, expUsed, modelCnt == DEPTH);
    end
    for (int i = 0; i < modelCnt; i++) begin
      checks++;
      if (cellKeys[i*KEY_W +: KEY_W] !== KEY_W'(modelKeys[i])) begin
        errors++;
        $display("FAIL %s cell %0d actual %0d expected %0d", req, i, cellKeys[i*KEY_W +: KEY_W], modelKeys[i]);
      end
    end
  endtask

  task automatic push(input int k);
    @(negedge clk); inValid = 1; inKey = KEY_W'(k);
    @(negedge clk); inValid = 0;
    modelInsert(k);
  endtask

  task automatic doClear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    modelCnt = 0;
  endtask

  task automatic testReset();
    compare("R1 reset");
  endtask

  task automatic testAscending();
    doClear();
    for (int k = 1; k <= 4; k++) begin push(k * 10); compare("R4 append"); end
  endtask

  task automatic testMiddle();
    doClear();
    push(50); push(20); compare("R2 displace top");
    push(30); compare("R3 insert middle");
    push(5); compare("R3 cell0 takes new");
  endtask

  task automatic testStable();
    doClear();
    push(40); push(40); push(10); push(40); compare("R6 equal keys");
  endtask

  task automatic testBackToBack();
    doClear();
    @(negedge clk); inValid = 1;
    inKey = 8'd90; @(negedge clk); modelInsert(90); compare("R7 back-to-back 1");
    inKey = 8'd70; @(negedge clk); modelInsert(70); compare("R7 back-to-back 2");
    inKey = 8'd80; @(negedge clk); modelInsert(80); compare("R7 back-to-back 3");
    inValid = 0;
  endtask

  task automatic testIdle();
    inKey = 8'd1;
    repeat (3) @(negedge clk);
    compare("R9 idle holds");
  endtask

  task automatic testFull();
    doClear();
    for (int k = 8; k >= 3; k--) push(k * 10);
    push(80); push(80);
    compare("R8 now full");
    push(1); compare("R8 push out last");
    push(80); compare("R8 equal to last dropped");
    push(200); compare("R8 largest new dropped");
  endtask

  task automatic testClearWins();
    @(negedge clk); clr = 1; inValid = 1; inKey = 8'd3;
    @(negedge clk); clr = 0; inValid = 0;
    modelCnt = 0;
    compare("R1 clear over insert");
    push(7); compare("R5 refill after clear");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1;
        testReset();
        testAscending();
        testMiddle();
        testStable();
        testBackToBack();
        testIdle();
        testFull();
        testClearWins();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule